// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the host-facing register layer of a multi-channel interval timer (three channels by default). A byte-wide bus with a 2-bit address reaches one data port per channel and a shared control port. Control words either configure a channel (access format, counting mode, BCD flag), freeze a channel's running count for a later read, or issue a read-back command that can freeze counts and status bytes for several channels at once.

The block moves 16-bit counts over the 8-bit bus in the byte order that was programmed for each channel. It raises a one-cycle load strobe, with the assembled count, toward the counter channel once the count is complete. It raises a one-cycle mode strobe when a channel's configuration changes. It samples each channel's live count, output level and null-count flag. The counting itself happens in the channels, outside this block.

Top module: `timer_regif`

## Requirements
- R1: Address 3 is the control port and a write there never raises a load strobe. Addresses 0 to 2 are the channel data ports. A read of address 3 returns 8'h00.
- R2: A control word with bits 7:6 = channel n (0 to 2) and bits 5:4 != 00 stores format = bits 5:4, mode = bits 3:1 and BCD = bit 0 for channel n. The mode and BCD outputs change, and the mode strobe for n is high, for the one cycle after the write.
- R3: With format 01 (low byte only) a data write loads {8'h00, byte}. With format 10 (high byte only) it loads {byte, 8'h00}. In both cases the load strobe is high in the cycle after the write, and at most one load strobe is high in any cycle.
- R4: With format 11, the first data write (low byte) raises no strobe. The second data write (high byte) raises the strobe with {high, low}.
- R5: With no latch pending, a read returns the live count. Format 11 alternates low byte then high byte, format 01 returns the low byte and format 10 returns the high byte.
- R6: A control word with bits 5:4 = 00 latches the channel's live count. Reads return the frozen value until it has been read in full in the programmed order. After that, reads return the live count again.
- R7: A count latch command, whether a latch word or a read-back, is ignored for a channel whose count latch is still pending.
- R8: Read-back (bits 7:6 = 11, bit 0 = 0) with bit 5 = 0 latches the count of each channel selected by bit 1 (ch0), bit 2 (ch1) and bit 3 (ch2). Unselected channels are untouched.
- R9: Read-back with bit 4 = 0 latches a status byte {OUT, null, format[1:0], mode[2:0], BCD}, with OUT and null sampled at the command.
- R10: When a status byte and a count are both latched, the first read returns the status and the following reads return the latched count.
- R11: A read-back word with bit 0 = 1 is ignored.
- R12: A configuring control word resets the channel's write-order and read-order flip-flops and drops its pending latches.
- R13: After reset every strobe is low, every mode and BCD output is 0, and every channel's format is 11 with both flip-flops on the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Port address: 0 to 2 are the channels, 3 is control |
| wr_en | input | 1 | Write this cycle |
| rd_en | input | 1 | Read this cycle; no effect while wr_en is high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |
| ch_cnt_i | input | 48 | Live 16-bit count per channel, channel 0 in the low bits |
| ch_out_i | input | 3 | Live OUT level per channel |
| ch_null_i | input | 3 | Live null-count flag per channel |
| ld_stb_o | output | 3 | Count load strobe per channel |
| ld_val_o | output | 48 | Count to load per channel |
| mode_stb_o | output | 3 | Configuration-change strobe per channel |
| ch_mode_o | output | 9 | Counting mode per channel, 3 bits each |
| ch_bcd_o | output | 1 per channel (3) | BCD flag per channel |

## Verification
The read data is combinational, so the bench samples it 1 ns after driving a read at a falling edge. The read's side effects (status consumed, flip-flop toggled, latch released) take hold at the next rising edge and show up in the following read. Load strobes, load values, mode strobes and the mode and BCD outputs are registered once. They are checked at the falling edge that follows the write's rising edge, the only cycle in which the strobes are high. Latch and read-back commands are proven by changing the live count between the command and the read, so a frozen value and a live value give different bytes.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 2 * BYTE_W;
   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LO    = 2'b01,
      ACC_HI    = 2'b10,
      ACC_BOTH  = 2'b11
   } acc_fmt_e;

   typedef struct packed {
      acc_fmt_e          fmt;
      logic [MODE_W-1:0] mode;
      logic              bcd;
   } chan_cfg_t;
endpackage

// File: rtl/timer_regif_decode.sv
module timer_regif_decode
   import timer_regif_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [1:0]              addr,
   input  logic [BYTE_W-1:0]       wdata,
   output logic [NUM_CH-1:0]       mode_wr,
   output logic [NUM_CH-1:0]       cnt_latch,
   output logic [NUM_CH-1:0]       st_latch,
   output logic [NUM_CH-1:0]       data_wr,
   output logic [NUM_CH-1:0]       data_rd,
   output chan_cfg_t               new_cfg
);
   localparam logic [1:0] CTL_ADDR = 2'd3;
   localparam logic [1:0] RB_SEL   = 2'b11;

   logic ctl_wr;
   logic rb_ok;

   assign ctl_wr  = wr_en && (addr == CTL_ADDR);
   assign rb_ok   = ctl_wr && (wdata[7:6] == RB_SEL) && !wdata[0];
   assign new_cfg = chan_cfg_t'(wdata[5:0]);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      logic sel_me;
      assign sel_me       = ctl_wr && (wdata[7:6] == 2'(i));
      assign mode_wr[i]   = sel_me && (wdata[5:4] != ACC_LATCH);
      assign cnt_latch[i] = (sel_me && (wdata[5:4] == ACC_LATCH)) ||
                            (rb_ok && !wdata[5] && wdata[i+1]);
      assign st_latch[i]  = rb_ok && !wdata[4] && wdata[i+1];
      assign data_wr[i]   = wr_en && (addr == 2'(i));
      assign data_rd[i]   = rd_en && !wr_en && (addr == 2'(i));
   end
endmodule

// File: rtl/timer_regif_chan.sv
module timer_regif_chan
   import timer_regif_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  chan_cfg_t         new_cfg,
   input  logic              cnt_latch,
   input  logic              st_latch,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  live_cnt,
   input  logic              live_out,
   input  logic              live_null,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              ld_stb,
   output logic [CNT_W-1:0]  ld_val,
   output logic              mode_stb,
   output chan_cfg_t         cfg
);
   logic              wff_q, rff_q;
   logic [BYTE_W-1:0] lo_hold_q;
   logic              cnt_pend_q, st_pend_q;
   logic [CNT_W-1:0]  cnt_lat_q;
   logic [BYTE_W-1:0] st_lat_q;
   logic [CNT_W-1:0]  rd_src;
   logic              rd_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg        <= '{fmt: ACC_BOTH, mode: '0, bcd: 1'b0};
         wff_q      <= 1'b0;
         rff_q      <= 1'b0;
         lo_hold_q  <= '0;
         cnt_pend_q <= 1'b0;
         st_pend_q  <= 1'b0;
         cnt_lat_q  <= '0;
         st_lat_q   <= '0;
         ld_stb     <= 1'b0;
         ld_val     <= '0;
         mode_stb   <= 1'b0;
      end else begin
         ld_stb   <= 1'b0;
         mode_stb <= 1'b0;
         if (mode_wr) begin
            cfg        <= new_cfg;
            wff_q      <= 1'b0;
            rff_q      <= 1'b0;
            cnt_pend_q <= 1'b0;
            st_pend_q  <= 1'b0;
            mode_stb   <= 1'b1;
         end else begin
            if (data_wr) begin
               unique case (cfg.fmt)
                  ACC_LO: begin
                     ld_val <= {{BYTE_W{1'b0}}, wdata};
                     ld_stb <= 1'b1;
                  end
                  ACC_HI: begin
                     ld_val <= {wdata, {BYTE_W{1'b0}}};
                     ld_stb <= 1'b1;
                  end
                  default: begin
                     if (!wff_q) begin
                        lo_hold_q <= wdata;
                        wff_q     <= 1'b1;
                     end else begin
                        ld_val <= {wdata, lo_hold_q};
                        ld_stb <= 1'b1;
                        wff_q  <= 1'b0;
                     end
                  end
               endcase
            end
            if (cnt_latch && !cnt_pend_q) begin
               cnt_lat_q  <= live_cnt;
               cnt_pend_q <= 1'b1;
            end
            if (st_latch && !st_pend_q) begin
               st_lat_q  <= {live_out, live_null, cfg};
               st_pend_q <= 1'b1;
            end
            if (data_rd) begin
               if (st_pend_q) begin
                  st_pend_q <= 1'b0;
               end else begin
                  if (cfg.fmt == ACC_BOTH) rff_q <= !rff_q;
                  if (cnt_pend_q && ((cfg.fmt != ACC_BOTH) || rff_q))
                     cnt_pend_q <= 1'b0;
               end
            end
         end
      end
   end

   always_comb begin
      rd_src = cnt_pend_q ? cnt_lat_q : live_cnt;
      rd_hi  = (cfg.fmt == ACC_HI) || ((cfg.fmt == ACC_BOTH) && rff_q);
      if (st_pend_q)  rd_byte = st_lat_q;
      else if (rd_hi) rd_byte = rd_src[CNT_W-1:BYTE_W];
      else            rd_byte = rd_src[BYTE_W-1:0];
   end

   // R4
   lo_byte_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !mode_wr && cfg.fmt == ACC_BOTH && !wff_q) |=> !ld_stb);

   // R6
   latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_pend_q && !mode_wr) |=> $stable(cnt_lat_q));

   // R12
   mode_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (!cnt_pend_q && !st_pend_q && !wff_q && !rff_q));

   // R10
   status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && st_pend_q) |=> (!st_pend_q && $stable(rff_q) && $stable(cnt_pend_q)));
endmodule

// File: rtl/timer_regif.sv
module timer_regif
   import timer_regif_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               addr,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata,
   input  logic [NUM_CH*16-1:0]     ch_cnt_i,
   input  logic [NUM_CH-1:0]        ch_out_i,
   input  logic [NUM_CH-1:0]        ch_null_i,
   output logic [NUM_CH-1:0]        ld_stb_o,
   output logic [NUM_CH*16-1:0]     ld_val_o,
   output logic [NUM_CH-1:0]        mode_stb_o,
   output logic [NUM_CH*3-1:0]      ch_mode_o,
   output logic [NUM_CH-1:0]        ch_bcd_o
);
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("timer_regif: NUM_CH must be 1 to 3");
   end
   if (CNT_W != 16 || MODE_W != 3) begin : g_bad_w
      $error("timer_regif: count must be 16 bits and mode 3 bits");
   end

   logic [NUM_CH-1:0] mode_wr, cnt_latch, st_latch, data_wr, data_rd;
   chan_cfg_t         new_cfg;
   logic [BYTE_W-1:0] rd_byte [NUM_CH];

   timer_regif_decode #(.NUM_CH(NUM_CH)) u_dec (
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .mode_wr   (mode_wr),
      .cnt_latch (cnt_latch),
      .st_latch  (st_latch),
      .data_wr   (data_wr),
      .data_rd   (data_rd),
      .new_cfg   (new_cfg)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chan_cfg_t cfg;
      timer_regif_chan u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode_wr   (mode_wr[i]),
         .new_cfg   (new_cfg),
         .cnt_latch (cnt_latch[i]),
         .st_latch  (st_latch[i]),
         .data_wr   (data_wr[i]),
         .data_rd   (data_rd[i]),
         .wdata     (wdata),
         .live_cnt  (ch_cnt_i[i*CNT_W +: CNT_W]),
         .live_out  (ch_out_i[i]),
         .live_null (ch_null_i[i]),
         .rd_byte   (rd_byte[i]),
         .ld_stb    (ld_stb_o[i]),
         .ld_val    (ld_val_o[i*CNT_W +: CNT_W]),
         .mode_stb  (mode_stb_o[i]),
         .cfg       (cfg)
      );
      assign ch_mode_o[i*MODE_W +: MODE_W] = cfg.mode;
      assign ch_bcd_o[i]                   = cfg.bcd;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (addr == 2'(i)) rdata = rd_byte[i];
   end

   // R3
   ld_stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_stb_o));

   // R1
   ctl_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3) |=> (ld_stb_o == '0));

   // R2
   mode_stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stb_o != '0) |-> ($past(wr_en) && $past(addr) == 2'd3));
endmodule

// File: tb/timer_regif_bench.sv
`timescale 1ns/1ps
module timer_regif_bench;
   localparam int NCH = 3;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_LV = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  addr;
      logic [15:0] arg;
      logic        stb;
      logic [15:0] val;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t VEC [NV] = '{
      '{OP_WR, 2'd3, 16'h0036, 1'b0, 16'h0000, 4'd2},  // R2 ch0 both-byte mode 3
      '{OP_WR, 2'd0, 16'h0034, 1'b0, 16'h0000, 4'd4},  // R4 low byte, no strobe
      '{OP_WR, 2'd0, 16'h0012, 1'b1, 16'h1234, 4'd4},  // R4 high byte loads
      '{OP_WR, 2'd3, 16'h0050, 1'b0, 16'h0000, 4'd2},  // ch1 low-only
      '{OP_WR, 2'd1, 16'h00AB, 1'b1, 16'h00AB, 4'd3},  // R3
      '{OP_WR, 2'd3, 16'h00A2, 1'b0, 16'h0000, 4'd2},  // ch2 high-only mode 1
      '{OP_WR, 2'd2, 16'h00CD, 1'b1, 16'hCD00, 4'd3},  // R3
      '{OP_LV, 2'd0, 16'h5678, 1'b0, 16'h0000, 4'd0},
      '{OP_RD, 2'd0, 16'h0078, 1'b0, 16'h0000, 4'd5},  // R5 live low
      '{OP_RD, 2'd0, 16'h0056, 1'b0, 16'h0000, 4'd5},  // R5 live high
      '{OP_WR, 2'd3, 16'h0000, 1'b0, 16'h0000, 4'd6},  // R6 latch ch0
      '{OP_LV, 2'd0, 16'h1111, 1'b0, 16'h0000, 4'd0},
      '{OP_RD, 2'd0, 16'h0078, 1'b0, 16'h0000, 4'd6},  // frozen low
      '{OP_WR, 2'd3, 16'h0000, 1'b0, 16'h0000, 4'd7},  // R7 second latch ignored
      '{OP_LV, 2'd0, 16'h2222, 1'b0, 16'h0000, 4'd0},
      '{OP_RD, 2'd0, 16'h0056, 1'b0, 16'h0000, 4'd7},  // still first value
      '{OP_RD, 2'd0, 16'h0022, 1'b0, 16'h0000, 4'd6},  // released, live
      '{OP_RD, 2'd0, 16'h0022, 1'b0, 16'h0000, 4'd6},
      '{OP_LV, 2'd1, 16'h0099, 1'b0, 16'h0000, 4'd0},
      '{OP_LV, 2'd2, 16'h7700, 1'b0, 16'h0000, 4'd0},
      '{OP_WR, 2'd3, 16'h00C4, 1'b0, 16'h0000, 4'd9},  // R9 read-back ch1 both
      '{OP_LV, 2'd1, 16'h0033, 1'b0, 16'h0000, 4'd0},
      '{OP_RD, 2'd1, 16'h0050, 1'b0, 16'h0000, 4'd10}, // R10 status first
      '{OP_RD, 2'd1, 16'h0099, 1'b0, 16'h0000, 4'd10}, // then count
      '{OP_RD, 2'd1, 16'h0033, 1'b0, 16'h0000, 4'd8},
      '{OP_WR, 2'd3, 16'h00D8, 1'b0, 16'h0000, 4'd8},  // R8 count ch2 only
      '{OP_LV, 2'd2, 16'h4400, 1'b0, 16'h0000, 4'd0},
      '{OP_RD, 2'd2, 16'h0077, 1'b0, 16'h0000, 4'd8},
      '{OP_RD, 2'd2, 16'h0044, 1'b0, 16'h0000, 4'd8},
      '{OP_WR, 2'd3, 16'h00C9, 1'b0, 16'h0000, 4'd11}, // R11 bit0 set
      '{OP_LV, 2'd2, 16'h5500, 1'b0, 16'h0000, 4'd0},
      '{OP_RD, 2'd2, 16'h0055, 1'b0, 16'h0000, 4'd11},
      '{OP_WR, 2'd3, 16'h00E8, 1'b0, 16'h0000, 4'd9},  // status only ch2
      '{OP_RD, 2'd2, 16'h00A2, 1'b0, 16'h0000, 4'd9},
      '{OP_RD, 2'd2, 16'h0055, 1'b0, 16'h0000, 4'd9},
      '{OP_RD, 2'd3, 16'h0000, 1'b0, 16'h0000, 4'd1},  // R1 control read
      '{OP_LV, 2'd1, 16'h0044, 1'b0, 16'h0000, 4'd0},
      '{OP_RD, 2'd1, 16'h0044, 1'b0, 16'h0000, 4'd8}   // ch1 untouched by ch2 read-back
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [15:0] live [NCH];
   logic [NCH*16-1:0] ch_cnt_i;
   logic [NCH-1:0] ch_out_i = 3'b101;
   logic [NCH-1:0] ch_null_i = 3'b010;
   logic [NCH-1:0] ld_stb_o, mode_stb_o, ch_bcd_o;
   logic [NCH*16-1:0] ld_val_o;
   logic [NCH*3-1:0] ch_mode_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   assign ch_cnt_i = {live[2], live[1], live[0]};

   timer_regif #(.NUM_CH(NCH)) u_timer_regif (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .ch_cnt_i(ch_cnt_i), .ch_out_i(ch_out_i),
      .ch_null_i(ch_null_i), .ld_stb_o(ld_stb_o), .ld_val_o(ld_val_o),
      .mode_stb_o(mode_stb_o), .ch_mode_o(ch_mode_o), .ch_bcd_o(ch_bcd_o)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1;
      check(rdata == exp, tag, 32'(rdata), 32'(exp));
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk_wr(input logic [1:0] a, input logic s, input logic [15:0] v, input string tag);
      logic [2:0] m;
      m = (a < 2'd3 && s) ? 3'(1 << a) : 3'b000;
      check(ld_stb_o == m, tag, 32'(ld_stb_o), 32'(m));
      if (a < 2'd3 && s)
         check(ld_val_o[a*16 +: 16] == v, tag, 32'(ld_val_o[a*16 +: 16]), 32'(v));
   endtask

   initial begin
      live[0] = 16'hA5C3; live[1] = '0; live[2] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state
      check(ld_stb_o == '0 && mode_stb_o == '0, "R13 strobes", 32'({ld_stb_o, mode_stb_o}), 0);
      check(ch_mode_o == '0 && ch_bcd_o == '0, "R13 cfg", 32'({ch_mode_o, ch_bcd_o}), 0);
      do_rd(2'd0, 8'hC3, "R13 low first");
      do_rd(2'd0, 8'hA5, "R13 high second");

      for (int k = 0; k < NV; k++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[k].req, k);
         case (VEC[k].op)
            OP_WR: begin
               do_wr(VEC[k].addr, VEC[k].arg[7:0]);
               chk_wr(VEC[k].addr, VEC[k].stb, VEC[k].val, tag);
            end
            OP_RD: do_rd(VEC[k].addr, VEC[k].arg[7:0], tag);
            default: live[VEC[k].addr] = VEC[k].arg;
         endcase
      end

      // R12 mode word resets flip-flops and drops latches
      do_wr(2'd0, 8'h99);
      chk_wr(2'd0, 1'b0, 16'h0, "R12 half write");
      do_rd(2'd0, 8'h22, "R12 live read");
      do_wr(2'd3, 8'h00);
      do_wr(2'd3, 8'h36);
      check(mode_stb_o == 3'b001, "R2 mode strobe", 32'(mode_stb_o), 1);
      do_wr(2'd0, 8'h01);
      chk_wr(2'd0, 1'b0, 16'h0, "R12 low after mode");
      do_wr(2'd0, 8'h02);
      chk_wr(2'd0, 1'b1, 16'h0201, "R12 high after mode");
      live[0] = 16'hBEEF;
      do_rd(2'd0, 8'hEF, "R12 latch dropped, low first");
      do_rd(2'd0, 8'hBE, "R12 high");

      // R2 BCD and mode outputs
      do_wr(2'd3, 8'h37);
      check(mode_stb_o == 3'b001, "R2 strobe", 32'(mode_stb_o), 1);
      check(ch_mode_o[2:0] == 3'd3 && ch_bcd_o[0], "R2 cfg", 32'({ch_mode_o[2:0], ch_bcd_o[0]}), 32'h7);
      check(ch_mode_o[8:6] == 3'd1 && ch_mode_o[5:3] == 3'd0, "R2 other ch", 32'(ch_mode_o), 32'h040);
      @(negedge clk);
      check(mode_stb_o == '0, "R2 strobe one cycle", 32'(mode_stb_o), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule